// File: doc/BRIEF.md
# Rollback Store Delay Buffer

This block sits between a processor's load/store port and its data cache. Every store, including the write half of a test-and-set, is held in a short shift queue for a fixed number of cycles before it reaches the cache's single write port. Error checking elsewhere in the system can then finish in parallel with execution. If a late error indication arrives, the processor asks for a rollback of a given number of cycles, and the stores issued in those cycles are cancelled before they ever touch the cache. Because nothing reaches the cache until it leaves the head of the queue, nothing in the cache or in memory beyond it ever has to be undone. Line fills caused by load misses are left in place.

Loads present their address to the cache read port and to the queue in the same cycle. The queue compares the address against every held store in two independent 15-bit sections. A held store matches only when both sections are equal. The newest matching store supplies the load data. With no match, the data comes from the cache. The queue advances one slot on every cycle. On a cycle without an accepted store it inserts an invalid placeholder, so a rollback depth counted in cycles selects exactly that many of the newest slots.

A test-and-set returns the old value and enqueues the new one. It also locks its block for the issuing requester until its write has drained into the cache. While the lock holds, another requester that touches the same block is told to wait with `busy`, and no second test-and-set is taken.

Top module: `rollback_store_buffer`

## Requirements
- R1: While reset is asserted and right after it, the queue is empty: `cacheWrEn`, `rdValid` and `busy` are low.
- R2: A store accepted in the cycle before clock edge t appears on `cacheWrEn`/`cacheWrAddr`/`cacheWrData` during the cycle that follows edge t+DEPTH-1, which is exactly DEPTH cycles after it was issued. Each accepted, uncancelled store is written once, and stores are written in issue order.
- R3: An accepted load or test-and-set raises `rdValid` in the same cycle. `rdData` comes from the newest queued store with an equal address; with no such store, `rdData` is `cacheRdData`.
- R4: `cacheRdAddr` equals `reqAddr` in the same cycle, so the cache lookup runs alongside the queue search.
- R5: A queued store matches a request only when both 15-bit address sections (bits 29..15 and bits 14..0) are equal. A difference in either section alone means no forwarding.
- R6: A rollback of depth p (`rbValid` high) cancels every store issued in the last p cycles, including a store at the head in that same cycle when p ≥ DEPTH. A depth above DEPTH acts as DEPTH, and depth 0 cancels nothing. A request presented in a rollback cycle is ignored: it gets no response, no store and no `busy`.
- R7: Every cycle advances the queue by one slot, whether it is idle, a load, a stalled request or a rollback. A store issued k cycles before a rollback of depth p < k survives.
- R8: A test-and-set (`reqTas` high, overriding `reqWrite`) returns the old value by the R3 rules and enqueues a store of `reqData` to the same address.
- R9: While a block (address bits 29..2) is locked, a load or store from a different `reqId` to that block raises `busy` and is not accepted. The lock owner's accesses and accesses to other blocks proceed.
- R10: Any test-and-set presented while a lock is active raises `busy`.
- R11: The lock ends with the clock edge at which its test-and-set store is written to the cache, or with a rollback that cancels that store.
- R12: `busy` is only raised for a valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqTas | input | 1 | Test-and-set, overrides reqWrite |
| reqId | input | 2 | Requester identity |
| reqAddr | input | 30 | Word address |
| reqData | input | 32 | Store data / value to set |
| busy | output | 1 | Request stalled by a lock; retry |
| rdValid | output | 1 | Load data valid this cycle |
| rdData | output | 32 | Load / old test-and-set value |
| cacheRdAddr | output | 30 | Cache read port address |
| cacheRdData | input | 32 | Cache read port data |
| cacheWrEn | output | 1 | Cache write strobe |
| cacheWrAddr | output | 30 | Cache write address |
| cacheWrData | output | 32 | Cache write data |
| rbValid | input | 1 | Rollback request |
| rbDepth | input | 3 | Number of cycles to roll back |

## Verification
The bench builds the block with its defaults: a four-slot queue, a 30-bit address split into two 15-bit sections, four-word blocks and two identity bits. With only four slots, the bench can reach a rollback that takes the head entry, a rollback deeper than the queue, and a test-and-set lock that lives through a full drain, all in a few cycles. With 15-bit sections, the bench can flip a single bit in either half to prove that each section takes part in the match.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_TAS   = 2'd3
  } sbuf_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;     // enqueue a real store in slot 0
    logic pushTas;  // that store is the write half of a test-and-set
  } sbuf_strobe_t;

endpackage

// File: rtl/sbuf_addr_cmp.sv
module sbuf_addr_cmp #(
  parameter int ADDR_W = 30,
  parameter int SEC_W  = 15
) (
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  output logic              equal
);
  localparam int NSEC = (ADDR_W + SEC_W - 1) / SEC_W;

  logic [NSEC-1:0] secEq;

  // each section compares on its own; the full match is their AND
  for (genvar s = 0; s < NSEC; s++) begin : gSec
    localparam int LO = s * SEC_W;
    localparam int HI = ((s + 1) * SEC_W > ADDR_W) ? ADDR_W - 1 : (s + 1) * SEC_W - 1;
    assign secEq[s] = (aAddr[HI:LO] == bAddr[HI:LO]);
  end

  assign equal = &secEq;
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int ADDR_W  = 30,
  parameter int ID_W    = 2,
  parameter int DEPTH   = 4,
  parameter int BLK_OFF = 2,
  localparam int BLK_W   = ADDR_W - BLK_OFF,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               reqTas,
  input  logic [ID_W-1:0]    reqId,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               rbValid,
  input  logic [DEPTH_W-1:0] rbDepth,
  input  logic               lockActive,
  input  logic [BLK_W-1:0]   lockBlk,
  input  logic [ID_W-1:0]    lockOwner,
  output sbuf_strobe_t       strobes,
  output logic [DEPTH-1:0]   killMask,
  output logic               busy,
  output logic               rdValid
);
  sbuf_op_e opKind;
  logic     foreignHit;
  logic     accept;

  always_comb begin
    if (!reqValid || rbValid) opKind = OP_NONE;
    else if (reqTas)          opKind = OP_TAS;
    else if (reqWrite)        opKind = OP_STORE;
    else                      opKind = OP_LOAD;
  end

  assign foreignHit = lockActive &&
                      (reqAddr[ADDR_W-1:BLK_OFF] == lockBlk) &&
                      (reqId != lockOwner);

  assign busy   = (opKind != OP_NONE) &&
                  (foreignHit || ((opKind == OP_TAS) && lockActive));
  assign accept = (opKind != OP_NONE) && !busy;

  assign strobes.push    = accept && ((opKind == OP_STORE) || (opKind == OP_TAS));
  assign strobes.pushTas = accept && (opKind == OP_TAS);
  assign rdValid         = accept && ((opKind == OP_LOAD) || (opKind == OP_TAS));

  // slot i holds the store of i+1 cycles ago; depth p kills slots 0..p-1
  for (genvar i = 0; i < DEPTH; i++) begin : gKill
    assign killMask[i] = rbValid && (rbDepth > DEPTH_W'(i));
  end
endmodule

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
#(
  parameter int ADDR_W  = 30,
  parameter int SEC_W   = 15,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 2,
  parameter int DEPTH   = 4,
  parameter int BLK_OFF = 2,
  localparam int BLK_W  = ADDR_W - BLK_OFF,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbuf_strobe_t      strobes,
  input  logic [DEPTH-1:0]  killMask,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [ID_W-1:0]   reqId,
  input  logic [DATA_W-1:0] cacheRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              lockActive,
  output logic [BLK_W-1:0]  lockBlk,
  output logic [ID_W-1:0]   lockOwner,
  output logic              cacheWrEn,
  output logic [ADDR_W-1:0] cacheWrAddr,
  output logic [DATA_W-1:0] cacheWrData
);
  logic [DEPTH-1:0]  qValid;
  logic [DEPTH-1:0]  qTas;
  logic [ADDR_W-1:0] qAddr [DEPTH];
  logic [DATA_W-1:0] qData [DEPTH];
  logic [ID_W-1:0]   qId   [DEPTH];
  logic [DEPTH-1:0]  addrEq;
  logic [DEPTH-1:0]  match;
  logic              fwdHit;
  logic [IDX_W-1:0]  fwdIdx;

  // slot 0: newest; takes a real store or an invalid placeholder every cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qValid[0] <= 1'b0;
      qTas[0]   <= 1'b0;
    end else begin
      qValid[0] <= strobes.push;
      qTas[0]   <= strobes.pushTas;
    end
  end

  always_ff @(posedge clk) begin
    qAddr[0] <= reqAddr;
    qData[0] <= reqData;
    qId[0]   <= reqId;
  end

  // older slots shift one place per cycle, dropping rolled-back entries
  for (genvar i = 1; i < DEPTH; i++) begin : gShift
    always_ff @(posedge clk) begin
      if (!rstN) begin
        qValid[i] <= 1'b0;
        qTas[i]   <= 1'b0;
      end else begin
        qValid[i] <= qValid[i-1] & ~killMask[i-1];
        qTas[i]   <= qTas[i-1]   & ~killMask[i-1];
      end
    end

    always_ff @(posedge clk) begin
      qAddr[i] <= qAddr[i-1];
      qData[i] <= qData[i-1];
      qId[i]   <= qId[i-1];
    end
  end

  // associative search, one sectioned comparator per slot
  for (genvar i = 0; i < DEPTH; i++) begin : gCam
    sbuf_addr_cmp #(
      .ADDR_W (ADDR_W),
      .SEC_W  (SEC_W)
    ) uCmp (
      .aAddr (qAddr[i]),
      .bAddr (reqAddr),
      .equal (addrEq[i])
    );
    assign match[i] = qValid[i] & addrEq[i];
  end

  // priority: lowest slot index is the most recent store
  always_comb begin
    fwdHit = 1'b0;
    fwdIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        fwdHit = 1'b1;
        fwdIdx = IDX_W'(i);
      end
    end
  end

  assign rdData = fwdHit ? qData[fwdIdx] : cacheRdData;

  // a lock lives exactly as long as its test-and-set store is queued
  always_comb begin
    lockActive = 1'b0;
    lockBlk    = '0;
    lockOwner  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (qValid[i] && qTas[i]) begin
        lockActive = 1'b1;
        lockBlk    = qAddr[i][ADDR_W-1:BLK_OFF];
        lockOwner  = qId[i];
      end
    end
  end

  // head drains to the cache unless a full-depth rollback takes it
  assign cacheWrEn   = qValid[DEPTH-1] & ~killMask[DEPTH-1];
  assign cacheWrAddr = qAddr[DEPTH-1];
  assign cacheWrData = qData[DEPTH-1];
endmodule

// File: rtl/rollback_store_buffer.sv
module rollback_store_buffer
  import sbuf_pkg::*;
#(
  parameter int ADDR_W  = 30,
  parameter int SEC_W   = 15,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 2,
  parameter int DEPTH   = 4,
  parameter int BLK_OFF = 2,
  localparam int BLK_W   = ADDR_W - BLK_OFF,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               reqTas,
  input  logic [ID_W-1:0]    reqId,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqData,
  output logic               busy,
  output logic               rdValid,
  output logic [DATA_W-1:0]  rdData,
  output logic [ADDR_W-1:0]  cacheRdAddr,
  input  logic [DATA_W-1:0]  cacheRdData,
  output logic               cacheWrEn,
  output logic [ADDR_W-1:0]  cacheWrAddr,
  output logic [DATA_W-1:0]  cacheWrData,
  input  logic               rbValid,
  input  logic [DEPTH_W-1:0] rbDepth
);
  sbuf_strobe_t     strobes;
  logic [DEPTH-1:0] killMask;
  logic             lockActive;
  logic [BLK_W-1:0] lockBlk;
  logic [ID_W-1:0]  lockOwner;

  assign cacheRdAddr = reqAddr;

  sbuf_ctrl #(
    .ADDR_W  (ADDR_W),
    .ID_W    (ID_W),
    .DEPTH   (DEPTH),
    .BLK_OFF (BLK_OFF)
  ) uCtrl (
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqTas     (reqTas),
    .reqId      (reqId),
    .reqAddr    (reqAddr),
    .rbValid    (rbValid),
    .rbDepth    (rbDepth),
    .lockActive (lockActive),
    .lockBlk    (lockBlk),
    .lockOwner  (lockOwner),
    .strobes    (strobes),
    .killMask   (killMask),
    .busy       (busy),
    .rdValid    (rdValid)
  );

  sbuf_datapath #(
    .ADDR_W  (ADDR_W),
    .SEC_W   (SEC_W),
    .DATA_W  (DATA_W),
    .ID_W    (ID_W),
    .DEPTH   (DEPTH),
    .BLK_OFF (BLK_OFF)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .killMask    (killMask),
    .reqAddr     (reqAddr),
    .reqData     (reqData),
    .reqId       (reqId),
    .cacheRdData (cacheRdData),
    .rdData      (rdData),
    .lockActive  (lockActive),
    .lockBlk     (lockBlk),
    .lockOwner   (lockOwner),
    .cacheWrEn   (cacheWrEn),
    .cacheWrAddr (cacheWrAddr),
    .cacheWrData (cacheWrData)
  );
endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
  parameter int DEPTH = 4,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqTas,
  input logic busy,
  input logic rdValid,
  input logic rbValid,
  input logic cacheWrEn
);
  logic [DEPTH_W-1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN)                              sinceRst <= '0;
    else if (sinceRst < DEPTH_W'(DEPTH))    sinceRst <= sinceRst + 1'b1;
  end

  assert_stall_no_resp_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !rdValid);

  assert_rollback_ignores_R6: assert property (@(posedge clk) disable iff (!rstN)
    rbValid |-> (!rdValid && !busy));

  assert_tas_then_lock_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqTas && !busy && !rbValid) |=>
      (!(reqValid && reqTas && !rbValid) || busy));

  assert_no_early_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < DEPTH_W'(DEPTH)) |-> !cacheWrEn);

  assert_busy_needs_req_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> reqValid);
endmodule

bind rollback_store_buffer sbuf_checker #(.DEPTH(DEPTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqTas    (reqTas),
  .busy      (busy),
  .rdValid   (rdValid),
  .rbValid   (rbValid),
  .cacheWrEn (cacheWrEn)
);

// File: tb/tb_rollback_store_buffer.sv
module tb_rollback_store_buffer;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqWrite = 0, reqTas = 0;
  logic [1:0]  reqId = 0;
  logic [29:0] reqAddr = 0;
  logic [31:0] reqData = 0;
  logic        busy, rdValid, cacheWrEn;
  logic [31:0] rdData, cacheWrData;
  logic [29:0] cacheRdAddr, cacheWrAddr;
  logic [31:0] cacheRdData = 0;
  logic        rbValid = 0;
  logic [2:0]  rbDepth = 0;

  always #5 clk = ~clk;

  rollback_store_buffer dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqTas(reqTas), .reqId(reqId), .reqAddr(reqAddr), .reqData(reqData),
    .busy(busy), .rdValid(rdValid), .rdData(rdData), .cacheRdAddr(cacheRdAddr),
    .cacheRdData(cacheRdData), .cacheWrEn(cacheWrEn), .cacheWrAddr(cacheWrAddr),
    .cacheWrData(cacheWrData), .rbValid(rbValid), .rbDepth(rbDepth));

  typedef struct {
    int          stamp;
    logic [29:0] addr;
    logic [31:0] data;
    logic [1:0]  id;
    bit          tas;
  } pend_t;

  pend_t pend[$];
  int    now = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phaseTag = "R1";

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s/%s at cycle %0d: actual=%h expected=%h", tag, phaseTag, now, act, exp);
    end
  endtask

  // one cycle: inputs already driven at negedge; compare, then advance model
  task automatic tick();
    bit          expBusy, expRd, expWr, lockOn, accept;
    logic [31:0] expData, expWrData;
    logic [29:0] expWrAddr, lockAddr;
    logic [1:0]  lockId;
    cacheRdData = {2'b00, reqAddr} ^ 32'hC0DE_0000;
    #1;
    expBusy = 0; expRd = 0; expData = cacheRdData; accept = 0;
    if (rbValid) begin
      for (int i = pend.size() - 1; i >= 0; i--)
        if (now - pend[i].stamp <= int'(rbDepth)) pend.delete(i);
    end
    lockOn = 0; lockAddr = 0; lockId = 0;
    foreach (pend[i]) if (pend[i].tas) begin
      lockOn = 1; lockAddr = pend[i].addr; lockId = pend[i].id;
    end
    if (reqValid && !rbValid) begin
      expBusy = (lockOn && reqAddr[29:2] == lockAddr[29:2] && reqId != lockId) ||
                (reqTas && lockOn);
      accept  = !expBusy;
      expRd   = accept && (reqTas || !reqWrite);
      foreach (pend[i]) if (pend[i].addr == reqAddr) expData = pend[i].data;
    end
    expWr = 0; expWrAddr = 0; expWrData = 0;
    foreach (pend[i]) if (now - pend[i].stamp == DEPTH) begin
      expWr = 1; expWrAddr = pend[i].addr; expWrData = pend[i].data;
    end
    chk("R12", 64'(busy), 64'(expBusy));
    chk("R3", 64'(rdValid), 64'(expRd));
    if (expRd) chk("R3", 64'(rdData), 64'(expData));
    chk("R4", 64'(cacheRdAddr), 64'(reqAddr));
    chk("R2", 64'(cacheWrEn), 64'(expWr));
    if (expWr) chk("R2", {cacheWrAddr, cacheWrData}, {expWrAddr, expWrData});
    @(posedge clk);
    for (int i = pend.size() - 1; i >= 0; i--)
      if (now - pend[i].stamp == DEPTH) pend.delete(i);
    if (accept && (reqTas || reqWrite))
      pend.push_back('{stamp: now, addr: reqAddr, data: reqData, id: reqId, tas: reqTas});
    now++;
    @(negedge clk);
  endtask

  task automatic drive(bit v, bit w, bit t, logic [1:0] id, logic [29:0] a,
                       logic [31:0] d, bit rb, logic [2:0] dep);
    reqValid = v; reqWrite = w; reqTas = t; reqId = id; reqAddr = a;
    reqData = d; rbValid = rb; rbDepth = dep;
    tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 30'h0, 0, 0, 0);
  endtask
  task automatic st(logic [1:0] id, logic [29:0] a, logic [31:0] d);
    drive(1, 1, 0, id, a, d, 0, 0);
  endtask
  task automatic ld(logic [1:0] id, logic [29:0] a);
    drive(1, 0, 0, id, a, 0, 0, 0);
  endtask
  task automatic tas(logic [1:0] id, logic [29:0] a, logic [31:0] d);
    drive(1, 0, 1, id, a, d, 0, 0);
  endtask
  task automatic rb(logic [2:0] dep);
    drive(0, 0, 0, 0, 30'h0, 0, 1, dep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", 64'(cacheWrEn), 64'(0));
    chk("R1", 64'(busy), 64'(0));
    chk("R1", 64'(rdValid), 64'(0));
    rstN = 1'b1;

    phaseTag = "R2";
    st(0, 30'h100, 32'h1111_0001);
    st(0, 30'h104, 32'h1111_0002);
    idle(6);

    phaseTag = "R3";
    st(0, 30'h200, 32'hAAAA_0001);
    ld(0, 30'h200);
    st(1, 30'h200, 32'hAAAA_0002);
    ld(0, 30'h200);
    ld(0, 30'h208);
    idle(5);

    phaseTag = "R5";
    st(0, 30'h12345, 32'h5555_0001);
    ld(0, 30'h12345 ^ 30'h0010_0000);
    ld(0, 30'h12345 ^ 30'h1);
    ld(0, 30'h12345);
    idle(5);

    phaseTag = "R6";
    st(0, 30'h300, 32'h6666_0001);
    st(0, 30'h301, 32'h6666_0002);
    st(0, 30'h302, 32'h6666_0003);
    st(0, 30'h303, 32'h6666_0004);
    rb(2);
    idle(5);
    st(0, 30'h310, 32'h6666_0010);
    st(0, 30'h311, 32'h6666_0011);
    st(0, 30'h312, 32'h6666_0012);
    st(0, 30'h313, 32'h6666_0013);
    rb(7);
    idle(5);
    st(0, 30'h320, 32'h6666_0020);
    drive(1, 1, 0, 0, 30'h321, 32'h6666_0021, 1, 0);
    ld(0, 30'h320);
    idle(5);

    phaseTag = "R7";
    st(0, 30'h400, 32'h7777_0001);
    ld(0, 30'h400);
    ld(0, 30'h404);
    rb(2);
    idle(5);

    phaseTag = "R8";
    st(0, 30'h500, 32'h8888_0001);
    tas(1, 30'h500, 32'h0000_0001);
    ld(1, 30'h500);
    idle(6);

    phaseTag = "R9";
    tas(1, 30'h40, 32'h0000_0001);
    ld(2, 30'h41);
    st(2, 30'h43, 32'h9999_0001);
    ld(1, 30'h42);
    st(2, 30'h80, 32'h9999_0002);
    phaseTag = "R10";
    tas(2, 30'h90, 32'h1);
    tas(1, 30'h44, 32'h1);
    phaseTag = "R11";
    ld(2, 30'h41);
    ld(2, 30'h41);
    ld(2, 30'h41);
    tas(3, 30'h600, 32'h1);
    ld(2, 30'h600);
    rb(1);
    ld(2, 30'h600);
    tas(2, 30'h604, 32'h1);
    idle(6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule